// File: doc/BRIEF.md
# Three-Phase Sine-Triangle PWM Generator

This block drives the six gates of a two-level, three-leg voltage-source inverter. A phase accumulator advances by a programmable step every enabled clock. It produces three reference phases that sit one third of a turn apart. A parabolic sine shaper turns each phase into a reference level, and the modulation index scales that level around the carrier midpoint.

All three levels are compared against a single triangular carrier. The carrier is locked to the accumulator, so its frequency is an exact integer multiple of the reference frequency. That multiple is forced onto an odd multiple of three, so triplen components cancel between the line voltages.

Reference levels are refreshed only at the carrier's peaks and troughs. The two gates of a leg are always complementary while the block is enabled. When the block is disabled or in reset, all six gates are held low.

Top module: `spwm_gen`

## Requirements
- R1: While `rst` is high, or after any clock edge at which `en` was low, all six gate outputs are 0 and the phase accumulator is 0. The first enabled edge therefore starts the waveform from phase zero.
- R2: The accumulator is 16 bits wide and adds `phase_inc` (modulo 2^16) at every enabled edge. Phase a uses the accumulator value. Phases b and c add 21845 and 43691 to it.
- R3: For a phase p, let h be bits [14:0] of p. Let m = floor(h*(32768-h)/16384), which is negative when bit 15 of p is set. The reference level is 16384 + floor(m*mod_index/256). `mod_index` is unsigned with 8 fraction bits, so 256 means an index of 1.0.
- R4: The reference level is clamped to the range -1 to 32768. Above index 1.0 the reference pins at these limits: the upper gate stays on at the top limit and stays off at the bottom limit.
- R5: The carrier phase c is the low 16 bits of accumulator times effective ratio. The carrier value is c[14:0] while c[15] is 0, and the bitwise inverse of c[14:0] while c[15] is 1. This gives a 15-bit triangle with its trough and its peak at the bit-15 transitions.
- R6: The effective ratio is registered one cycle after `ratio_cfg`. It is the largest odd multiple of 3 that does not exceed `ratio_cfg`, limited to the range 3 to 45. A value below 3 gives 3.
- R7: A leg's reference sample is reloaded only when bit 15 of the carrier phase differs from its value registered at the previous edge, or while `en` is low. The sample is the reset value 16384 until the first reload.
- R8: At each enabled edge, the upper gate of a leg is set to 1 when its held reference sample is greater than or equal to the current carrier value, and to 0 otherwise. The comparison is registered.
- R9: After every enabled edge, each leg's lower gate equals the inverse of its upper gate. The two gates of a leg are never both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Modulation enable |
| mod_index | input | 10 | Modulation index, 8 fraction bits |
| phase_inc | input | 16 | Reference phase step per clock |
| ratio_cfg | input | 6 | Requested carrier-to-reference ratio |
| gate_hi | output | 3 | Upper switch commands, bit 0 = leg a |
| gate_lo | output | 3 | Lower switch commands, bit 0 = leg a |

## Verification
At a carrier peak or trough, a leg reloads its reference sample in the same cycle that it compares the old sample against the carrier. A wrong ordering shifts the gate edge by one cycle right where the triangle turns. The bench provokes this by running slow and fast phase steps against many ratio settings, and by changing `ratio_cfg` and `en` on arbitrary cycles so that they land on boundary cycles. Every cycle it judges all six gates against a cycle model that applies the reload after the compare.

// File: rtl/spwm_pkg.sv
package spwm_pkg;
    parameter int PH_W      = 16;
    parameter int RAT_W     = 6;
    parameter int MI_W      = 10;
    parameter int MI_FRAC   = 8;
    parameter int MAX_RATIO = 45;
    parameter int NLEG      = 3;

    localparam int K       = PH_W - 1;
    localparam int REF_W   = PH_W + 1;
    localparam int FULL_HI = 2 ** K;
    localparam int MID     = 2 ** (K - 1);
    localparam int QMAX    = MAX_RATIO / 3;

    typedef logic [PH_W-1:0]         phase_t;
    typedef logic [K-1:0]            carrier_t;
    typedef logic signed [REF_W-1:0] level_t;

    function automatic phase_t leg_offset(input int idx);
        longint v;
        v = (longint'(idx) * (longint'(1) <<< PH_W) + 1) / 3;
        return phase_t'(v);
    endfunction

    function automatic level_t ref_level(input phase_t ph, input logic [MI_W-1:0] mi);
        int x;
        int mag;
        int s;
        int v;
        x   = int'(ph[K-1:0]);
        mag = (x * (FULL_HI - x)) >>> (K - 1);
        s   = ph[K] ? -mag : mag;
        v   = MID + ((s * int'(mi)) >>> MI_FRAC);
        if (v > FULL_HI) v = FULL_HI;
        if (v < -1) v = -1;
        return level_t'(v);
    endfunction

    function automatic logic [RAT_W-1:0] ratio_fix(input logic [RAT_W-1:0] r);
        int q;
        q = int'(r) / 3;
        if (q > QMAX) q = QMAX;
        if (q < 1) q = 1;
        if ((q % 2) == 0) q = q - 1;
        return RAT_W'(3 * q);
    endfunction
endpackage

// File: rtl/spwm_phase_acc.sv
module spwm_phase_acc
    import spwm_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   en,
    input  phase_t phase_inc,
    output phase_t acc,
    output phase_t leg_phase [NLEG]
);
    always_ff @(posedge clk) begin
        if (rst || !en) acc <= '0;
        else            acc <= acc + phase_inc;
    end

    for (genvar g = 0; g < NLEG; g++) begin : g_off
        assign leg_phase[g] = acc + leg_offset(g);
    end
endmodule

// File: rtl/spwm_carrier.sv
module spwm_carrier
    import spwm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  phase_t           acc,
    input  logic [RAT_W-1:0] ratio_cfg,
    output carrier_t         tri_val,
    output logic             refresh,
    output logic [RAT_W-1:0] ratio_eff
);
    phase_t cp;
    logic   half_q;

    assign cp      = acc * {{(PH_W-RAT_W){1'b0}}, ratio_eff};
    assign tri_val = cp[K] ? ~cp[K-1:0] : cp[K-1:0];
    assign refresh = !en || (cp[K] != half_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            ratio_eff <= RAT_W'(3);
            half_q    <= 1'b0;
        end else begin
            ratio_eff <= ratio_fix(ratio_cfg);
            half_q    <= en ? cp[K] : 1'b0;
        end
    end
endmodule

// File: rtl/spwm_leg.sv
module spwm_leg
    import spwm_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            en,
    input  logic            refresh,
    input  phase_t          phase,
    input  logic [MI_W-1:0] mod_index,
    input  carrier_t        tri_val,
    output level_t          level_q,
    output logic            hi,
    output logic            lo
);
    level_t carrier_s;
    logic   above;

    assign carrier_s = $signed({{(REF_W-K){1'b0}}, tri_val});
    assign above     = (level_q >= carrier_s);

    always_ff @(posedge clk) begin
        if (rst) begin
            level_q <= level_t'(MID);
            hi      <= 1'b0;
            lo      <= 1'b0;
        end else begin
            if (refresh) level_q <= ref_level(phase, mod_index);
            hi <= en && above;
            lo <= en && !above;
        end
    end
endmodule

// File: rtl/spwm_gen.sv
module spwm_gen
    import spwm_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   en,
    input  logic [MI_W-1:0]        mod_index,
    input  logic [PH_W-1:0]        phase_inc,
    input  logic [RAT_W-1:0]       ratio_cfg,
    output logic [NLEG-1:0]        gate_hi,
    output logic [NLEG-1:0]        gate_lo
);
    phase_t           acc_w;
    phase_t           leg_phase [NLEG];
    carrier_t         tri_w;
    logic             refresh_w;
    logic [RAT_W-1:0] ratio_w;
    level_t           level_w [NLEG];

    spwm_phase_acc u_acc (
        .clk       (clk),
        .rst       (rst),
        .en        (en),
        .phase_inc (phase_inc),
        .acc       (acc_w),
        .leg_phase (leg_phase)
    );

    spwm_carrier u_car (
        .clk       (clk),
        .rst       (rst),
        .en        (en),
        .acc       (acc_w),
        .ratio_cfg (ratio_cfg),
        .tri_val   (tri_w),
        .refresh   (refresh_w),
        .ratio_eff (ratio_w)
    );

    for (genvar g = 0; g < NLEG; g++) begin : g_leg
        spwm_leg u_leg (
            .clk       (clk),
            .rst       (rst),
            .en        (en),
            .refresh   (refresh_w),
            .phase     (leg_phase[g]),
            .mod_index (mod_index),
            .tri_val   (tri_w),
            .level_q   (level_w[g]),
            .hi        (gate_hi[g]),
            .lo        (gate_lo[g])
        );
    end
endmodule

// File: rtl/spwm_chk.sv
module spwm_chk
    import spwm_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             en,
    input logic [PH_W-1:0]  phase_inc,
    input logic [NLEG-1:0]  gate_hi,
    input logic [NLEG-1:0]  gate_lo,
    input logic [PH_W-1:0]  acc,
    input logic [RAT_W-1:0] ratio,
    input logic             refresh,
    input level_t           level_a
);
    // R1
    idle_gates_low_chk: assert property (@(posedge clk) disable iff (rst)
        $past(!en) |-> (gate_hi == '0 && gate_lo == '0));

    // R1
    idle_acc_zero_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(!en) && $past(!rst)) |-> (acc == '0));

    // R2
    acc_step_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(en) && $past(!rst)) |-> (acc == $past(acc) + $past(phase_inc)));

    // R6
    ratio_legal_chk: assert property (@(posedge clk) disable iff (rst)
        ((ratio % 3) == 0) && (((ratio / 3) % 2) == 1) && (int'(ratio) <= MAX_RATIO));

    // R7
    level_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(!refresh) && $past(!rst)) |-> $stable(level_a));

    // R9
    leg_pair_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(en) && $past(!rst)) |-> (gate_hi == ~gate_lo));

    // R9
    no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
        (gate_hi & gate_lo) == '0);
endmodule

bind spwm_gen spwm_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .phase_inc (phase_inc),
    .gate_hi   (gate_hi),
    .gate_lo   (gate_lo),
    .acc       (acc_w),
    .ratio     (ratio_w),
    .refresh   (refresh_w),
    .level_a   (level_w[0])
);

// File: tb/sim_spwm_gen.sv
module sim_spwm_gen;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en  = 1'b0;
    logic [9:0] mod_index = '0;
    logic [15:0] phase_inc = '0;
    logic [5:0] ratio_cfg = '0;
    logic [2:0] gate_hi;
    logic [2:0] gate_lo;

    int n_cmp = 0;
    int n_bad = 0;
    string tag = "R1";

    int m_acc = 0;
    int m_half = 0;
    int m_rat = 3;
    int m_lvl [3] = '{16384, 16384, 16384};
    logic [2:0] m_hi = '0;
    logic [2:0] m_lo = '0;
    logic last_en = 1'b0;
    logic last_rst = 1'b1;

    always #4 clk = ~clk;

    spwm_gen u0 (
        .clk(clk), .rst(rst), .en(en), .mod_index(mod_index),
        .phase_inc(phase_inc), .ratio_cfg(ratio_cfg),
        .gate_hi(gate_hi), .gate_lo(gate_lo)
    );

    function automatic int b_level(input int ph, input int mi);
        int h = ph % 32768;
        int m = (h * (32768 - h)) / 16384;
        int s = (ph >= 32768) ? -m : m;
        int v = 16384 + ((s * mi) >>> 8);
        if (v > 32768) v = 32768;
        if (v < -1) v = -1;
        return v;
    endfunction

    function automatic int b_ratio(input int cfg);
        int r = cfg;
        if (r > 45) r = 45;
        if (r < 3) r = 3;
        while (!((r % 3 == 0) && ((r / 3) % 2 == 1))) r = r - 1;
        return r;
    endfunction

    function automatic int b_carrier(input int cp);
        int low = cp % 32768;
        return (cp >= 32768) ? (32767 - low) : low;
    endfunction

    task automatic check_outputs();
        n_cmp++;
        if (gate_hi !== m_hi || gate_lo !== m_lo) begin
            n_bad++;
            $display("FAIL %s: gate_hi=%b gate_lo=%b expected hi=%b lo=%b",
                     tag, gate_hi, gate_lo, m_hi, m_lo);
        end
        if (last_en && !last_rst) begin
            // R9: complementary legs after an enabled edge
            n_cmp++;
            if (gate_hi !== ~gate_lo) begin
                n_bad++;
                $display("FAIL R9: gate_hi=%b gate_lo=%b expected lo=%b",
                         gate_hi, gate_lo, ~gate_hi);
            end
        end
    endtask

    task automatic model_edge(input logic r, input logic e, input int inc,
                              input int cfg, input int mi);
        int cp;
        int car;
        int half;
        int nl [3];
        if (r) begin
            m_acc = 0; m_half = 0; m_rat = 3;
            for (int i = 0; i < 3; i++) m_lvl[i] = 16384;
            m_hi = '0; m_lo = '0;
            return;
        end
        cp   = (m_acc * m_rat) % 65536;
        car  = b_carrier(cp);
        half = cp / 32768;
        for (int i = 0; i < 3; i++) begin
            int off = (i == 0) ? 0 : ((i == 1) ? 21845 : 43691);
            nl[i] = b_level((m_acc + off) % 65536, mi);
        end
        if (e) begin
            for (int i = 0; i < 3; i++) begin
                m_hi[i] = (m_lvl[i] >= car);
                m_lo[i] = !(m_lvl[i] >= car);
            end
        end else begin
            m_hi = '0; m_lo = '0;
        end
        if (!e || half != m_half)
            for (int i = 0; i < 3; i++) m_lvl[i] = nl[i];
        m_half = e ? half : 0;
        m_acc  = e ? (m_acc + inc) % 65536 : 0;
        m_rat  = b_ratio(cfg);
    endtask

    task automatic step(input logic r, input logic e, input int inc,
                        input int cfg, input int mi);
        @(negedge clk);
        check_outputs();
        rst = r; en = e;
        phase_inc = 16'(inc); ratio_cfg = 6'(cfg); mod_index = 10'(mi);
        last_en = e; last_rst = r;
        model_edge(r, e, inc, cfg, mi);
    endtask

    task automatic run(input int cycles, input int inc, input int cfg, input int mi);
        for (int c = 0; c < cycles; c++) step(1'b0, 1'b1, inc, cfg, mi);
    endtask

    initial begin
        #(8 * 150000);
        n_bad++;
        $display("FAIL watchdog: run incomplete, expected finish before limit");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int cfgs [7] = '{0, 2, 9, 12, 18, 47, 63};
        void'($urandom(32'd1234));
        tag = "R1";
        for (int c = 0; c < 3; c++) step(1'b1, 1'b0, 0, 9, 0);
        for (int c = 0; c < 5; c++) step(1'b0, 1'b0, 700, 9, 200);
        tag = "R6";
        for (int k = 0; k < 7; k++) begin
            run(350, 1500, cfgs[k], 200);
            tag = "R1";
            step(1'b0, 1'b0, 1500, cfgs[k], 200);
            tag = "R6";
        end
        tag = "R3";
        run(300, 900, 9, 0);
        run(300, 900, 15, 256);
        tag = "R4";
        run(400, 1100, 9, 1023);
        run(300, 1100, 21, 384);
        tag = "R7";
        run(1500, 37, 9, 230);
        tag = "R8";
        run(600, 4001, 45, 255);
        tag = "R5";
        run(600, 65535, 27, 180);
        tag = "R2";
        for (int s = 0; s < 60; s++) begin
            int inc = 100 + int'($urandom_range(0, 3900));
            int mi  = int'($urandom_range(0, 1023));
            for (int c = 0; c < 150; c++) begin
                int u = int'($urandom_range(0, 99));
                int cfg = int'($urandom_range(0, 63));
                step(u == 0, u > 4, inc, (c % 50 == 0) ? cfg : int'(ratio_cfg), mi);
            end
        end
        tag = "R1";
        step(1'b1, 1'b1, 500, 9, 200);
        step(1'b0, 1'b0, 500, 9, 200);
        step(1'b0, 1'b0, 500, 9, 200);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule